// File: doc/BRIEF.md
# Five-Channel Timer Match and Pin Action Unit

The unit watches a 16-bit free-running timer value supplied from outside and compares it against five compare registers, one per channel. When the timer steps onto a channel's compare value, that channel records a flag, may raise the shared interrupt line, and applies a pin action. Channels 2 to 5 each drive their own pin with a programmable action: keep, toggle, drive low or drive high. Channel 1 is the master channel. Its pin action writes a chosen data value onto any chosen subset of all five pins, and on a pin where it acts it overrides the action of the pin's own channel.

A force register lets software fire any channel's pin action at once, without waiting for a timer match. A forced action changes only pins. It leaves the flags and the interrupt line alone. Software reaches every register over a simple register port. A write takes effect on the clock edge where `reg_we` is high, and reads are combinational from `reg_addr`. The port has no handshake and no back-pressure: every access completes in the cycle it is presented. The pins and the interrupt line are plain level outputs.

Top module: `ocu_top`

## Requirements
- R1: After reset every register reads 0 (compare registers included), all five pins are 0 and `irq` is 0.
- R2: When the timer value sampled on a clock edge differs from the value on the previous edge and equals a channel's compare register, that channel's flag reads 1 two edges after the new timer value was first sampled. The flag register holds channel 1 at bit 7 down to channel 5 at bit 3 (address 9).
- R3: While the timer value does not change, no new match is detected: a cleared flag stays 0 and the pins hold.
- R4: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a match and a clear arrive together, the match wins.
- R5: `irq` is 1 exactly when some channel has both its flag and its enable bit set. The enable register is at address 10, with channel 1 at bit 7 down to channel 5 at bit 3.
- R6: The control register (address 5) holds a 2-bit action code for each of channels 2 to 5, at bits 7:6, 5:4, 3:2 and 1:0 in that order. The codes are 00 keep, 01 toggle, 10 drive low and 11 drive high. On a match the action is applied to the channel's own pin: channel 2 drives `pin_out[1]` and so on up to channel 5 on `pin_out[4]`.
- R7: The master mask register (address 6) and the master data register (address 7) use bit 7 for `pin_out[0]` down to bit 3 for `pin_out[4]`. On a channel-1 match, each pin whose mask bit is 1 takes its data bit.
- R8: Writing 1 to a bit of the force register (address 8, channel 1 at bit 7 down to channel 5 at bit 3) applies that channel's pin action one edge after the write edge. It sets no flag and does not raise `irq`.
- R9: When channel 1 and a pin's own channel act on that pin in the same cycle, the channel-1 data value wins.
- R10: The force register, and any address above 10, always read 0.
- R11: Compare registers (addresses 0 to 4 for channels 1 to 5) read back all 16 bits. The control register reads back all 8 bits. In the mask, data, flag and enable registers, bits 2:0 and 15:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Running timer value from the external counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| pin_out | output | 5 | Action pins; bit 0 belongs to channel 1 |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds the timer on a compare value after a match and clears the flag. A design that re-detected an unchanged timer value would set the flag again. It steps several channels onto one shared compare value under every action code and checks the resulting pin pattern. This catches a swapped control field, a toggle applied twice, or codes for low and high that are exchanged. It then lets channel 1 and channel 2 hit the same pin in the same cycle with opposite values, which exposes a design that lets the wrong channel win. Finally it forces pin actions and checks that the flags and the interrupt line stay quiet and that the force register reads 0. A design that routed a force through the flag logic would show a flag bit there.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int NCH    = 5;           // channel count
  localparam int AW     = 4;           // register address width
  localparam int RB     = 8;           // width of byte-wide registers
  localparam int FB_TOP = RB - 1;      // bus bit carrying channel 1 in per-channel fields

  localparam logic [AW-1:0] A_CMP1  = 4'd0;   // compare registers at A_CMP1 .. A_CMP1+NCH-1
  localparam logic [AW-1:0] A_CTRL  = 4'd5;
  localparam logic [AW-1:0] A_MASK  = 4'd6;
  localparam logic [AW-1:0] A_DATA  = 4'd7;
  localparam logic [AW-1:0] A_FORCE = 4'd8;
  localparam logic [AW-1:0] A_FLAG  = 4'd9;
  localparam logic [AW-1:0] A_EN    = 4'd10;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } pin_act_e;
endpackage

// File: rtl/ocu_cmp.sv
module ocu_cmp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr,
  input  logic          tmr_moved,
  input  logic [TW-1:0] cmp,
  output logic          hit_q
);
  // A match counts only on the edge where the timer has just stepped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= tmr_moved && (tmr == cmp);
  end
endmodule

// File: rtl/ocu_regs.sv
module ocu_regs
  import ocu_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [TW-1:0]           wdata,
  input  logic [NCH-1:0]          hit,
  output logic [TW-1:0]           rdata,
  output logic [NCH-1:0][TW-1:0]  cmp,
  output logic [NCH-2:0][1:0]     act,
  output logic [NCH-1:0]          mask,
  output logic [NCH-1:0]          data,
  output logic [NCH-1:0]          frc,
  output logic [NCH-1:0]          flag,
  output logic [NCH-1:0]          en,
  output logic                    irq
);
  localparam int CTRL_W = 2 * (NCH - 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, wr_mask, wr_data, wr_force, wr_flag, wr_en;

  assign wr_ctrl  = we && (addr == A_CTRL);
  assign wr_mask  = we && (addr == A_MASK);
  assign wr_data  = we && (addr == A_DATA);
  assign wr_force = we && (addr == A_FORCE);
  assign wr_flag  = we && (addr == A_FLAG);
  assign wr_en    = we && (addr == A_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp    <= '0;
      ctrl_q <= '0;
      mask   <= '0;
      data   <= '0;
      frc    <= '0;
      flag   <= '0;
      en     <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (we && (addr == A_CMP1 + AW'(i))) cmp[i] <= wdata;
        if (wr_mask) mask[i] <= wdata[FB_TOP-i];
        if (wr_data) data[i] <= wdata[FB_TOP-i];
        if (wr_en)   en[i]   <= wdata[FB_TOP-i];
        // force is a one-cycle pulse; the register itself holds nothing readable
        frc[i]  <= wr_force && wdata[FB_TOP-i];
        // a new match takes priority over a simultaneous clear
        flag[i] <= hit[i] | (flag[i] & ~(wr_flag && wdata[FB_TOP-i]));
      end
    end
  end

  // channel 2 takes the top pair of the control byte, channel NCH the bottom pair
  always_comb begin
    for (int j = 0; j < NCH - 1; j++) begin
      act[j] = ctrl_q[2*(NCH-2-j) + 1 -: 2];
    end
  end

  assign irq = |(flag & en);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == A_CMP1 + AW'(i)) rdata = cmp[i];
    end
    case (addr)
      A_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
      A_MASK: for (int i = 0; i < NCH; i++) rdata[FB_TOP-i] = mask[i];
      A_DATA: for (int i = 0; i < NCH; i++) rdata[FB_TOP-i] = data[i];
      A_FLAG: for (int i = 0; i < NCH; i++) rdata[FB_TOP-i] = flag[i];
      A_EN:   for (int i = 0; i < NCH; i++) rdata[FB_TOP-i] = en[i];
      default: ;
    endcase
  end
endmodule

// File: rtl/ocu_pins.sv
module ocu_pins
  import ocu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      hit,
  input  logic [NCH-1:0]      frc,
  input  logic [NCH-2:0][1:0] act,
  input  logic [NCH-1:0]      mask,
  input  logic [NCH-1:0]      data,
  output logic [NCH-1:0]      pins_q
);
  logic [NCH-1:0] fire;
  logic [NCH-1:0] pins_d;

  assign fire = hit | frc;

  always_comb begin
    pins_d = pins_q;
    // own-channel actions on pins 1..NCH-1
    for (int j = 0; j < NCH - 1; j++) begin
      if (fire[j+1]) begin
        case (pin_act_e'(act[j]))
          ACT_FLIP: pins_d[j+1] = ~pins_q[j+1];
          ACT_CLR:  pins_d[j+1] = 1'b0;
          ACT_SET:  pins_d[j+1] = 1'b1;
          default:  ;
        endcase
      end
    end
    // master channel applied last so it wins on any pin it covers
    if (fire[0]) begin
      for (int p = 0; p < NCH; p++) begin
        if (mask[p]) pins_d[p] = data[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end
endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] reg_rdata,
  output logic [NCH-1:0] pin_out,
  output logic          irq
);
  logic [TW-1:0]          tmr_prev;
  logic                   tmr_moved;
  logic [NCH-1:0]         hit_q;
  logic [NCH-1:0][TW-1:0] cmp_q;
  logic [NCH-2:0][1:0]    act_q;
  logic [NCH-1:0]         mask_q, data_q, frc_q, flag_q, en_q;

  // previous timer sample, loaded on every edge including during reset
  always_ff @(posedge clk) tmr_prev <= timer_val;
  assign tmr_moved = (timer_val != tmr_prev);

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    ocu_cmp #(.TW(TW)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr       (timer_val),
      .tmr_moved (tmr_moved),
      .cmp       (cmp_q[c]),
      .hit_q     (hit_q[c])
    );
  end

  ocu_regs #(.TW(TW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .hit   (hit_q),
    .rdata (reg_rdata),
    .cmp   (cmp_q),
    .act   (act_q),
    .mask  (mask_q),
    .data  (data_q),
    .frc   (frc_q),
    .flag  (flag_q),
    .en    (en_q),
    .irq   (irq)
  );

  ocu_pins u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_q),
    .frc    (frc_q),
    .act    (act_q),
    .mask   (mask_q),
    .data   (data_q),
    .pins_q (pin_out)
  );
endmodule

// File: rtl/ocu_checker.sv
module ocu_checker
  import ocu_pkg::*;
#(
  parameter int TW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TW-1:0]  timer_val,
  input logic           reg_we,
  input logic [AW-1:0]  reg_addr,
  input logic [TW-1:0]  reg_wdata,
  input logic [TW-1:0]  reg_rdata,
  input logic [NCH-1:0] pin_out,
  input logic           irq,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] frc,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] en
);
  // R3: an unchanged timer value never produces a match pulse
  p_no_redetect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(timer_val) |=> !(|hit));

  // R3: with no match and no force pending, the pins hold
  p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|hit) && !(|frc)) |=> $stable(pin_out));

  // R5: the interrupt needs a flagged and enabled channel
  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(flag & en)));

  // R10: force register always reads zero
  p_force_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FORCE) |-> (reg_rdata == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R4: write-one clears a flag when no match competes
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && reg_we && (reg_addr == A_FLAG) && reg_wdata[FB_TOP-i] && !hit[i]) |=> !flag[i]);

    // R8: a flag only rises after a real match, never after a force alone
    p_flag_from_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(hit[i]));
  end
endmodule

bind ocu_top ocu_checker #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .timer_val (timer_val),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .irq       (irq),
  .hit       (hit_q),
  .frc       (frc_q),
  .flag      (flag_q),
  .en        (en_q)
);

// File: tb/sim_ocu_top.sv
`timescale 1ns/1ps
module sim_ocu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] timer_val;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [4:0]  pin_out;
  logic        irq;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ocu_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_out   (pin_out),
    .irq       (irq)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // new timer value, then two edges: match pulse, then flag and pins
  task automatic tick(input logic [15:0] v);
    timer_val = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], d);
      check("R1", $sformatf("reg %0d after reset", a), {16'h0, d}, 32'h0);
    end
    check("R1", "pins after reset", {27'h0, pin_out}, 32'h0);
    check("R1", "irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_readback;
    logic [15:0] d;
    wr(4'd0, 16'h1111); wr(4'd1, 16'h1234); wr(4'd2, 16'h3333);
    wr(4'd3, 16'h4444); wr(4'd4, 16'h5555);
    rd(4'd1, d); check("R11", "cmp2 readback", {16'h0, d}, 32'h1234);
    rd(4'd4, d); check("R11", "cmp5 readback", {16'h0, d}, 32'h5555);
    wr(4'd5, 16'hFFA5); rd(4'd5, d); check("R11", "ctrl readback", {16'h0, d}, 32'h00A5);
    wr(4'd6, 16'hFFFF); rd(4'd6, d); check("R11", "mask unused bits", {16'h0, d}, 32'h00F8);
    wr(4'd7, 16'h0007); rd(4'd7, d); check("R11", "data unused bits", {16'h0, d}, 32'h0000);
    wr(4'd10, 16'hFFFF); rd(4'd10, d); check("R11", "enable readback", {16'h0, d}, 32'h00F8);
    rd(4'd13, d); check("R10", "unmapped address", {16'h0, d}, 32'h0);
    wr(4'd5, 16'h0); wr(4'd6, 16'h0); wr(4'd10, 16'h0);
  endtask

  task automatic t_match_flag;
    logic [15:0] d;
    tick(16'h1233);
    tick(16'h1234);
    rd(4'd9, d); check("R2", "ch2 flag on match", {16'h0, d}, 32'h0040);
    wr(4'd9, 16'h0000);
    rd(4'd9, d); check("R4", "write 0 keeps flag", {16'h0, d}, 32'h0040);
    wr(4'd9, 16'h0040);
    rd(4'd9, d); check("R4", "write 1 clears flag", {16'h0, d}, 32'h0000);
    repeat (4) @(negedge clk);
    rd(4'd9, d); check("R3", "held timer no re-detect", {16'h0, d}, 32'h0000);
    check("R3", "pins unchanged", {27'h0, pin_out}, 32'h0);
  endtask

  task automatic t_irq;
    tick(16'h1233);
    tick(16'h1234);
    check("R5", "irq with enable off", {31'h0, irq}, 32'h0);
    wr(4'd10, 16'h0040);
    check("R5", "irq with matching enable", {31'h0, irq}, 32'h1);
    wr(4'd10, 16'h0020);
    check("R5", "irq with other enable", {31'h0, irq}, 32'h0);
    wr(4'd10, 16'h0000);
    wr(4'd9, 16'h00F8);
  endtask

  task automatic t_actions;
    wr(4'd0, 16'hFFF0);
    for (int c = 1; c < 5; c++) wr(c[3:0], 16'h2000);
    // ch2 high, ch3 toggle, ch4 low, ch5 keep
    wr(4'd5, 16'h00D8);
    tick(16'h1FFF); tick(16'h2000);
    check("R6", "actions set/toggle/low/keep", {27'h0, pin_out}, 32'h06);
    // ch2 high, ch3 toggle, ch4 high, ch5 toggle
    wr(4'd5, 16'h00DD);
    tick(16'h1FFF); tick(16'h2000);
    check("R6", "second action pass", {27'h0, pin_out}, 32'h1A);
    // only ch4 low
    wr(4'd5, 16'h0008);
    tick(16'h1FFF); tick(16'h2000);
    check("R6", "drive low only ch4", {27'h0, pin_out}, 32'h12);
  endtask

  task automatic t_master;
    wr(4'd5, 16'h0000);
    wr(4'd6, 16'h0088);
    wr(4'd7, 16'h0080);
    wr(4'd0, 16'h3000);
    tick(16'h2FFF); tick(16'h3000);
    check("R7", "master mask/data on pins 0,4", {27'h0, pin_out}, 32'h03);
  endtask

  task automatic t_conflict;
    wr(4'd5, 16'h00C0);
    wr(4'd0, 16'h4000);
    wr(4'd1, 16'h4000);
    wr(4'd6, 16'h0040);
    wr(4'd7, 16'h0000);
    tick(16'h3FFF); tick(16'h4000);
    check("R9", "master data wins over ch2 high", {27'h0, pin_out}, 32'h01);
  endtask

  task automatic t_force;
    logic [15:0] d;
    wr(4'd9, 16'h00F8);
    wr(4'd10, 16'h00F8);
    check("R8", "irq quiet before force", {31'h0, irq}, 32'h0);
    wr(4'd6, 16'h0000);
    wr(4'd5, 16'h0010);
    wr(4'd8, 16'h0020);
    @(negedge clk);
    check("R8", "forced ch3 toggle", {27'h0, pin_out}, 32'h05);
    rd(4'd9, d); check("R8", "force sets no flag", {16'h0, d}, 32'h0);
    check("R8", "force raises no irq", {31'h0, irq}, 32'h0);
    wr(4'd5, 16'h0000);
    wr(4'd6, 16'h0088);
    wr(4'd7, 16'h0008);
    wr(4'd8, 16'h0080);
    @(negedge clk);
    check("R8", "forced master action", {27'h0, pin_out}, 32'h14);
    rd(4'd8, d); check("R10", "force reads zero", {16'h0, d}, 32'h0);
    rd(4'd9, d); check("R8", "no flag after master force", {16'h0, d}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; timer_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_match_flag();
    t_irq();
    t_actions();
    t_master();
    t_conflict();
    t_force();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule